// File: doc/BRIEF.md
# IDE DMA Sector Transfer Sequencer

This block does the sector bookkeeping for an IDE DMA command whose data moves in pieces. Each piece is one descriptor, given as an address and a byte length. The block supports two device kinds. For a hard disk it counts in 512-byte sectors. For an ATAPI packet device it counts in 2048-byte blocks and keeps a byte offset inside the current block. For every descriptor it issues one read or write request to a storage port. When that request completes, it moves the position forward and lowers the remaining count. It also reports completion through a status byte and a one-cycle interrupt pulse, and it tells the descriptor engine that the descriptor is finished.

A command is loaded first. The load gives the device kind, the direction, the starting sector (or the starting block for ATAPI), the sector count and the packet byte count. Descriptors then follow one at a time. Each descriptor runs in four steps:
1. An accounting pass runs on an empty chunk, so the first pass changes nothing.
2. If the length is non-zero, one request is issued and the block waits for the storage response.
3. A second accounting pass runs on the chunk that was just moved.
4. The end-of-DMA pulse ends the descriptor.

A flush input waits until no request is outstanding and then answers.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, `status` is 0x00, `irq`, `end_dma`, `req_valid` and `flush_done` are low, and `desc_ready` is high. Loading a command sets `status` to the busy code 0x80.
- R2: The accounting pass at the start of each descriptor uses a chunk size of zero. So the first request of a command targets exactly the loaded start sector on a disk, and sector start×4 on ATAPI.
- R3: On a disk, a completed chunk of L bytes moves the sector forward by ceil(L/512) and lowers the remaining sector count by the same amount. The next request's `req_sector` shows the new sector.
- R4: On a disk, when an accounting pass with a non-zero chunk brings the remaining sector count to exactly zero, `status` becomes 0x50 and `irq` pulses for one cycle.
- R5: A descriptor of zero length gives an `end_dma` pulse and no request. Every descriptor ends with exactly one `end_dma` pulse, and `req_valid` is low in that cycle.
- R6: A request carries the descriptor's address and length. `req_write` is 1 when the loaded command is a write and 0 when it is a read.
- R7: On ATAPI, a completed chunk is added to the byte offset. The block address moves forward by offset/2048, and the offset keeps its low 11 bits. The request targets the 512-byte sector block×4 + offset/512.
- R8: On ATAPI, a completed chunk is subtracted from a signed remaining packet byte count. Each accounting pass with a non-zero chunk that leaves the count at zero or below sets `status` to 0x40 and pulses `irq`.
- R9: A response with `rsp_err` high sets `status` to 0x41 and pulses `irq` and `end_dma` in the next cycle.
- R10: A request that is refused (`req_nack` high with `req_ready`) sets `status` to 0x41 and pulses `irq` and `end_dma` in the next cycle, with no response awaited.
- R11: At most one request is outstanding. `req_valid` and its fields hold until `req_ready`, and drop after an accepted request. After `flush`, `flush_done` stays low while a request is pending and rises once none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_load | input | 1 | Load a new command (honoured while idle) |
| cmd_atapi | input | 1 | 1 = ATAPI packet device, 0 = disk |
| cmd_write | input | 1 | 1 = write to storage, 0 = read |
| cmd_start | input | SEC_W | Starting sector (disk) or 2048-byte block (ATAPI) |
| cmd_sectors | input | CNT_W | Disk sector count |
| cmd_bytes | input | PKT_W | ATAPI packet byte count |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high with desc_valid |
| desc_addr | input | ADDR_W | Descriptor memory address |
| desc_len | input | LEN_W | Descriptor byte length |
| req_valid | output | 1 | Storage request pending |
| req_ready | input | 1 | Storage port takes the request |
| req_nack | input | 1 | Storage port refuses the request (with req_ready) |
| req_write | output | 1 | Request direction |
| req_addr | output | ADDR_W | Memory address of the chunk |
| req_len | output | LEN_W | Byte length of the chunk |
| req_sector | output | SEC_W | Target 512-byte sector |
| rsp_valid | input | 1 | Storage request finished |
| rsp_err | input | 1 | Storage request failed |
| flush | input | 1 | Ask to drain the outstanding request |
| flush_done | output | 1 | No request outstanding after a flush |
| end_dma | output | 1 | One-cycle end-of-descriptor pulse |
| irq | output | 1 | One-cycle interrupt pulse |
| status | output | 8 | Device status byte |

## Verification
The bench targets five corner cases, each of which a faulty design would get visibly wrong:
- A disk chunk that is not a whole number of sectors. A design that truncates instead of rounding up would leave sectors remaining and never raise the completion interrupt.
- ATAPI offsets that cross one or two 2048-byte blocks. A design that drops the offset carry would aim the second request at the wrong sector.
- A packet count that goes below zero. An unsigned count would wrap, and the command would never complete.
- A zero-length descriptor after completion. A faulty design would issue a stray request or raise a second interrupt.
- Errors and refusals, plus a flush issued mid-request. A faulty design would hang waiting for a response, report the wrong status, or answer the flush while storage still owns the buffer.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCT,
        ST_REQ,
        ST_WAIT
    } seq_state_e;

    localparam logic [7:0] STAT_RESET     = 8'h00;
    localparam logic [7:0] STAT_BUSY      = 8'h80;
    localparam logic [7:0] STAT_DISK_DONE = 8'h50;
    localparam logic [7:0] STAT_PKT_DONE  = 8'h40;
    localparam logic [7:0] STAT_FAIL      = 8'h41;

    localparam int SECTOR_SHIFT = 9;
    localparam int BLOCK_SHIFT  = 11;

endpackage

// File: rtl/ide_dma_acct.sv
// Combinational accounting step: applies one completed chunk to the
// disk or packet-device position and reports completion.
module ide_dma_acct #(
    parameter int LEN_W = 16,
    parameter int SEC_W = 32,
    parameter int CNT_W = 16,
    parameter int PKT_W = 24,
    localparam int LBA_W = SEC_W - 2
) (
    input  logic                    atapi,
    input  logic [LEN_W-1:0]        chunk,
    input  logic [SEC_W-1:0]        sector,
    input  logic signed [CNT_W:0]   nsect,
    input  logic [LBA_W-1:0]        lba,
    input  logic [10:0]             off,
    input  logic signed [PKT_W:0]   pkt,
    output logic [SEC_W-1:0]        sector_n,
    output logic signed [CNT_W:0]   nsect_n,
    output logic [LBA_W-1:0]        lba_n,
    output logic [10:0]             off_n,
    output logic signed [PKT_W:0]   pkt_n,
    output logic                    finished,
    output logic [SEC_W-1:0]        target
);
    import ide_dma_pkg::*;

    logic [LEN_W:0] rounded;
    logic [LEN_W:0] step;
    logic [LEN_W:0] ofs_sum;

    always_comb begin
        rounded  = {1'b0, chunk} + (LEN_W+1)'(511);
        step     = rounded >> SECTOR_SHIFT;
        ofs_sum  = (LEN_W+1)'(off) + (LEN_W+1)'(chunk);
        sector_n = sector;
        nsect_n  = nsect;
        lba_n    = lba;
        off_n    = off;
        pkt_n    = pkt;
        finished = 1'b0;
        if (chunk != '0) begin
            if (atapi) begin
                pkt_n    = pkt - $signed((PKT_W+1)'(chunk));
                lba_n    = lba + LBA_W'(ofs_sum >> BLOCK_SHIFT);
                off_n    = ofs_sum[10:0];
                finished = (pkt_n <= 0);
            end else begin
                sector_n = sector + SEC_W'(step);
                nsect_n  = nsect - $signed((CNT_W+1)'(step));
                finished = (nsect_n == 0);
            end
        end
        if (atapi) begin
            target = SEC_W'({lba_n, 2'b00}) + SEC_W'(off_n[10:9]);
        end else begin
            target = sector_n;
        end
    end

endmodule

// File: rtl/ide_dma_flush.sv
// Holds a flush request until no storage request is outstanding.
module ide_dma_flush (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic outstanding_i,
    output logic flush_done_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = flush_i | (pend_q & outstanding_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign flush_done_o = pend_q & ~outstanding_i;

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEC_W  = 32,
    parameter int CNT_W  = 16,
    parameter int PKT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic              cmd_atapi,
    input  logic              cmd_write,
    input  logic [SEC_W-1:0]  cmd_start,
    input  logic [CNT_W-1:0]  cmd_sectors,
    input  logic [PKT_W-1:0]  cmd_bytes,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              req_nack,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [SEC_W-1:0]  req_sector,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic              flush,
    output logic              flush_done,
    output logic              end_dma,
    output logic              irq,
    output logic [7:0]        status
);
    import ide_dma_pkg::*;

    localparam int LBA_W = SEC_W - 2;

    typedef struct packed {
        seq_state_e              st;
        logic                    atapi;
        logic                    wr;
        logic [ADDR_W-1:0]       io_addr;
        logic [LEN_W-1:0]        io_len;
        logic [LEN_W-1:0]        chunk;
        logic [SEC_W-1:0]        sector;
        logic signed [CNT_W:0]   nsect;
        logic [LBA_W-1:0]        lba;
        logic [10:0]             off;
        logic signed [PKT_W:0]   pkt;
        logic [ADDR_W-1:0]       r_addr;
        logic [LEN_W-1:0]        r_len;
        logic [SEC_W-1:0]        r_sector;
        logic                    end_p;
        logic                    irq_p;
        logic [7:0]              stat;
    } seq_t;

    seq_t q, d;

    logic [SEC_W-1:0]      a_sector, a_target;
    logic signed [CNT_W:0] a_nsect;
    logic [LBA_W-1:0]      a_lba;
    logic [10:0]           a_off;
    logic signed [PKT_W:0] a_pkt;
    logic                  a_fin;
    logic                  outstanding;
    logic                  wait_st;

    ide_dma_acct #(
        .LEN_W(LEN_W), .SEC_W(SEC_W), .CNT_W(CNT_W), .PKT_W(PKT_W)
    ) u_acct (
        .atapi    (q.atapi),
        .chunk    (q.chunk),
        .sector   (q.sector),
        .nsect    (q.nsect),
        .lba      (q.lba),
        .off      (q.off),
        .pkt      (q.pkt),
        .sector_n (a_sector),
        .nsect_n  (a_nsect),
        .lba_n    (a_lba),
        .off_n    (a_off),
        .pkt_n    (a_pkt),
        .finished (a_fin),
        .target   (a_target)
    );

    assign outstanding = (q.st == ST_REQ) || (q.st == ST_WAIT);
    assign wait_st     = (q.st == ST_WAIT);

    ide_dma_flush u_flush (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush),
        .outstanding_i (outstanding),
        .flush_done_o  (flush_done)
    );

    always_comb begin
        d       = q;
        d.end_p = 1'b0;
        d.irq_p = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_load) begin
                    d.atapi  = cmd_atapi;
                    d.wr     = cmd_write;
                    d.sector = cmd_start;
                    d.lba    = cmd_start[LBA_W-1:0];
                    d.off    = '0;
                    d.nsect  = $signed({1'b0, cmd_sectors});
                    d.pkt    = $signed({1'b0, cmd_bytes});
                    d.stat   = STAT_BUSY;
                end else if (desc_valid) begin
                    d.io_addr = desc_addr;
                    d.io_len  = desc_len;
                    d.chunk   = '0;
                    d.st      = ST_ACCT;
                end
            end
            ST_ACCT: begin
                d.sector = a_sector;
                d.nsect  = a_nsect;
                d.lba    = a_lba;
                d.off    = a_off;
                d.pkt    = a_pkt;
                if (a_fin) begin
                    d.stat  = q.atapi ? STAT_PKT_DONE : STAT_DISK_DONE;
                    d.irq_p = 1'b1;
                end
                if (q.io_len == '0) begin
                    d.end_p = 1'b1;
                    d.chunk = '0;
                    d.st    = ST_IDLE;
                end else begin
                    d.r_addr   = q.io_addr;
                    d.r_len    = q.io_len;
                    d.r_sector = a_target;
                    d.chunk    = q.io_len;
                    d.io_addr  = q.io_addr + ADDR_W'(q.io_len);
                    d.io_len   = '0;
                    d.st       = ST_REQ;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    if (req_nack) begin
                        d.stat  = STAT_FAIL;
                        d.irq_p = 1'b1;
                        d.end_p = 1'b1;
                        d.chunk = '0;
                        d.st    = ST_IDLE;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        d.stat  = STAT_FAIL;
                        d.irq_p = 1'b1;
                        d.end_p = 1'b1;
                        d.chunk = '0;
                        d.st    = ST_IDLE;
                    end else begin
                        d.st = ST_ACCT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.stat <= STAT_RESET;
        end else begin
            q <= d;
        end
    end

    assign desc_ready = (q.st == ST_IDLE) && !cmd_load;
    assign req_valid  = (q.st == ST_REQ);
    assign req_write  = q.wr;
    assign req_addr   = q.r_addr;
    assign req_len    = q.r_len;
    assign req_sector = q.r_sector;
    assign end_dma    = q.end_p;
    assign irq        = q.irq_p;
    assign status     = q.stat;

endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_nack,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic [SEC_W-1:0]  req_sector,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              wait_st,
    input logic              flush_done,
    input logic              end_dma,
    input logic              irq,
    input logic [7:0]        status
);
    import ide_dma_pkg::*;

    // R11: a pending request holds its fields until taken
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_len) && $stable(req_sector));

    // R11: an accepted request is followed by waiting, never a second request
    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_nack |=> !req_valid && wait_st);

    // R11: flush answer only with nothing outstanding
    a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !req_valid && !wait_st);

    // R5: end of descriptor never overlaps a request
    a_r5_end_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        end_dma |-> !req_valid);

    // R9: storage error ends the descriptor with failure status
    a_r9_err_end: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st && rsp_valid && rsp_err |=> end_dma && irq && status == STAT_FAIL);

    // R10: refused request ends the descriptor with failure status
    a_r10_nack_end: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_nack |=> end_dma && irq && status == STAT_FAIL);

    // R4 / R8: interrupt always comes with a completion or failure code
    a_r4_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status == STAT_DISK_DONE || status == STAT_PKT_DONE
                 || status == STAT_FAIL));

    // R6: descriptor intake and request issue are exclusive
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_ready && req_valid));

endmodule

bind ide_dma_seq ide_dma_seq_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_W(SEC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_ready (desc_ready),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_nack   (req_nack),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_sector (req_sector),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .wait_st    (wait_st),
    .flush_done (flush_done),
    .end_dma    (end_dma),
    .irq        (irq),
    .status     (status)
);

// File: tb/tb_ide_dma_seq.sv
`timescale 1ns/1ps
module tb_ide_dma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_load = 0, cmd_atapi = 0, cmd_write = 0;
    logic [31:0] cmd_start = 0;
    logic [15:0] cmd_sectors = 0;
    logic [23:0] cmd_bytes = 0;
    logic        desc_valid = 0;
    logic        desc_ready;
    logic [31:0] desc_addr = 0;
    logic [15:0] desc_len = 0;
    logic        req_valid, req_ready = 0, req_nack = 0, req_write;
    logic [31:0] req_addr, req_sector;
    logic [15:0] req_len;
    logic        rsp_valid = 0, rsp_err = 0;
    logic        flush = 0, flush_done, end_dma, irq;
    logic [7:0]  status;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ide_dma_seq dut (.*);

    typedef struct packed {
        logic        atapi;
        logic        wr;
        logic [31:0] start;
        logic [15:0] sects;
        logic [23:0] bytes;
        logic [15:0] len1;
        logic [15:0] len2;
        logic [31:0] exp1;
        logic [31:0] exp2;
        logic [7:0]  st1;
        logic [7:0]  st2;
        logic [1:0]  irq_at;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'd100,  16'd3, 24'd0,    16'd1024, 16'd512,  32'd100,  32'd102, 8'h80, 8'h50, 2'b10},
        '{1'b0, 1'b1, 32'd4096, 16'd2, 24'd0,    16'd600,  16'd0,    32'd4096, 32'd0,   8'h50, 8'h50, 2'b01},
        '{1'b1, 1'b0, 32'd10,   16'd0, 24'd4096, 16'd1536, 16'd2560, 32'd40,   32'd43,  8'h80, 8'h40, 2'b10},
        '{1'b1, 1'b0, 32'd5,    16'd0, 24'd1000, 16'd700,  16'd700,  32'd20,   32'd21,  8'h80, 8'h40, 2'b10},
        '{1'b1, 1'b1, 32'd0,    16'd0, 24'd2048, 16'd2048, 16'd512,  32'd0,    32'd4,   8'h40, 8'h40, 2'b11}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_cmd(input logic at, input logic wr, input logic [31:0] st,
                            input logic [15:0] ns, input logic [23:0] nb);
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        cmd_load = 1; cmd_atapi = at; cmd_write = wr;
        cmd_start = st; cmd_sectors = ns; cmd_bytes = nb;
        @(negedge clk);
        cmd_load = 0;
    endtask

    task automatic do_desc(input logic [31:0] a, input logic [15:0] l,
                           input bit nack, input bit err,
                           output bit got_req, output logic [31:0] sec,
                           output logic [31:0] raddr, output logic [15:0] rlen,
                           output bit rw, output bit got_irq, output bit got_end);
        bit adv;
        got_req = 0; got_irq = 0; got_end = 0; sec = 0; raddr = 0; rlen = 0; rw = 0;
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1; desc_addr = a; desc_len = l;
        @(negedge clk);
        desc_valid = 0;
        for (int k = 0; k < 100 && !got_end; k++) begin
            adv = 1;
            if (irq) got_irq = 1;
            if (end_dma) begin
                got_end = 1;
            end else if (req_valid) begin
                got_req = 1; sec = req_sector; raddr = req_addr;
                rlen = req_len; rw = req_write;
                req_ready = 1; req_nack = nack;
                @(negedge clk);
                req_ready = 0; req_nack = 0;
                if (!nack) begin
                    @(negedge clk);
                    @(negedge clk);
                    rsp_valid = 1; rsp_err = err;
                    @(negedge clk);
                    rsp_valid = 0; rsp_err = 0;
                end
                adv = 0;
            end
            if (adv && !got_end) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit gr, gi, ge, rw, seen;
        logic [31:0] sec, ra;
        logic [15:0] rl;

        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset desc_ready", desc_ready, 1);
        chk("R1 reset outputs", {req_valid, irq, end_dma, flush_done}, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load_cmd(VECS[i].atapi, VECS[i].wr, VECS[i].start, VECS[i].sects, VECS[i].bytes);
            chk("R1 busy after load", status, 8'h80);
            do_desc(32'h1000_0000 + i * 32'h100, VECS[i].len1, 0, 0, gr, sec, ra, rl, rw, gi, ge);
            chk("R2 first request issued", gr, 1);
            chk("R2/R7 first target sector", sec, VECS[i].exp1);
            chk("R6 request address", ra, 32'h1000_0000 + i * 32'h100);
            chk("R6 request length", rl, VECS[i].len1);
            chk("R6 request direction", rw, VECS[i].wr);
            chk("R5 end after desc1", ge, 1);
            chk("R4/R8 status after desc1", status, VECS[i].st1);
            chk("R4/R8 irq after desc1", gi, VECS[i].irq_at[0]);
            do_desc(32'h2000_0000 + i * 32'h100, VECS[i].len2, 0, 0, gr, sec, ra, rl, rw, gi, ge);
            chk("R5 end after desc2", ge, 1);
            if (VECS[i].len2 == 0) begin
                chk("R5 zero length issues no request", gr, 0);
            end else begin
                chk("R3/R7 second target sector", sec, VECS[i].exp2);
                chk("R6 second address", ra, 32'h2000_0000 + i * 32'h100);
            end
            chk("R4/R8 status after desc2", status, VECS[i].st2);
            chk("R4/R8 irq after desc2", gi, VECS[i].irq_at[1]);
        end

        // R9: storage error
        load_cmd(0, 0, 32'd50, 16'd8, 24'd0);
        do_desc(32'h3000_0000, 16'd512, 0, 1, gr, sec, ra, rl, rw, gi, ge);
        chk("R9 error ends dma", ge, 1);
        chk("R9 error irq", gi, 1);
        chk("R9 error status", status, 8'h41);

        // R10: refused request (ATAPI)
        load_cmd(1, 0, 32'd7, 16'd0, 24'd4096);
        do_desc(32'h3100_0000, 16'd2048, 1, 0, gr, sec, ra, rl, rw, gi, ge);
        chk("R10 refused request seen", gr, 1);
        chk("R10 refused ends dma", ge, 1);
        chk("R10 refused irq", gi, 1);
        chk("R10 refused status", status, 8'h41);

        // R11: flush waits for outstanding request
        load_cmd(0, 1, 32'd200, 16'd4, 24'd0);
        @(negedge clk);
        desc_valid = 1; desc_addr = 32'h4000_0000; desc_len = 16'd512;
        @(negedge clk);
        desc_valid = 0;
        for (int k = 0; k < 20 && !req_valid; k++) @(negedge clk);
        chk("R11 request pending", req_valid, 1);
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        chk("R11 no second request while waiting", req_valid, 0);
        flush = 1;
        @(negedge clk);
        flush = 0;
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            if (flush_done) seen = 1;
            @(negedge clk);
        end
        chk("R11 flush held while outstanding", seen, 0);
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            if (flush_done) seen = 1;
            @(negedge clk);
        end
        chk("R11 flush answered after response", seen, 1);
        for (int k = 0; k < 10 && !desc_ready; k++) @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        chk("R11 idle flush answered at once", flush_done, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule